// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog counter that sits on a small 32-bit register bus. The bus has an address, a write strobe, write data and read data. Software loads a 15-bit timeout, counted in 10 ms ticks, and starts the countdown. It must then keep reloading the counter before it runs out. Every control action takes effect only when the low 16 bits of the written word match a fixed key, so a stray write cannot start, feed or stop the timer. Stopping takes two keyed writes to two different registers in strict succession.

An internal prescaler divides the system clock down to the 100 Hz tick. The prescaler phase restarts on every reload, so a reload always grants the full timeout. When the count crosses half of the programmed timeout, a maskable early-warning interrupt is raised. When the count reaches zero, a sticky expiry code is latched and a reset pulse of fixed length is driven out. A debug-mode input, combined with a register bit, can freeze the countdown while a debugger holds the chip.

Top module: `wdg_magic_top`

## Requirements
- R1: After reset the timer is stopped. The stop-state register (0x0C) reads 0xDABE, the timeout register (0x04) and the count both hold 0x7FFF, the expiry register (0x10) reads 0x0000, and `irq_o` and `wdog_rst_o` are low.
- R2: A write to 0x04 stores bits [14:0] of the data as the timeout. A read of 0x04 returns those bits and zero above them.
- R3: Writing 0xACED to 0x1C starts the timer and loads the count from the timeout. The count then falls by one every CLK_DIV clock cycles, counted from the load. Any other value written to 0x1C has no effect. The count is read at 0x14, bits [14:0].
- R4: Writing 0xFEED to 0x00 reloads the count from the timeout and restarts the prescaler phase. Any other value leaves the count unchanged.
- R5: The timer stops only when a write of 0x2BAD to 0x08 is followed directly by a write of 0xCAFE to 0x0C. Any other write in between, or a different value at 0x0C, abandons the sequence. When stopped, 0x0C reads 0xDABE and the count holds still; when running, 0x0C reads 0x0000.
- R6: When the count steps to zero, 0x10 reads 0xCFE8 and `wdog_rst_o` goes high for exactly RST_LEN (16) cycles. The count then stays at zero.
- R7: Writing 0xE8B4 to 0x10 clears the latched expiry code back to 0x0000. Other values leave it set.
- R8: When the count steps onto the timeout divided by two (rounded down), bit 0 of 0x20 becomes 1. Writing 1 to bit 0 of 0x20 clears it; writing 0 does nothing. `irq_o` equals that bit ANDed with bit 0 of the mask register 0x24.
- R9: Writing 1 to bit 0 of 0x28 sets bit 0 of 0x20; writing 0 does nothing.
- R10: While `jtag_mode_i` is high and bit 0 of 0x18 is 0, the count and prescaler hold still. Reads of 0x18 return `jtag_mode_i` in bit 1 and the enable bit in bit 0.
- R11: Bit 15 of 0x14 reads 1 only in the clock cycle in which the count is about to step on a tick, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register byte address, shared by reads and writes |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for `bus_addr_i` |
| jtag_mode_i | input | 1 | Debug-mode indication |
| irq_o | output | 1 | Masked early-warning interrupt |
| wdog_rst_o | output | 1 | Reset request pulse on expiry |

## Verification
The assertions take for granted that `bus_addr_i` is held steady around every clock edge at which `bus_we_i` is high. They also assume `jtag_mode_i` is a clean synchronous level. The freeze and step properties compare the count across single edges, so they rely on no load and no tick being hidden by a glitching input. The stimulus changes every input only between a falling and a rising edge, and it issues one write per cycle. It toggles the debug-mode input only while no write is pending.

// File: rtl/wdg_magic_pkg.sv
`timescale 1ns/1ps
package wdg_magic_pkg;
  localparam int CNT_W = 15;
  localparam int KEY_W = 16;

  localparam logic [7:0] OFS_RELOAD  = 8'h00;
  localparam logic [7:0] OFS_LIMIT   = 8'h04;
  localparam logic [7:0] OFS_HALT_A  = 8'h08;
  localparam logic [7:0] OFS_HALT_B  = 8'h0C;
  localparam logic [7:0] OFS_EXPIRY  = 8'h10;
  localparam logic [7:0] OFS_COUNT   = 8'h14;
  localparam logic [7:0] OFS_DEBUG   = 8'h18;
  localparam logic [7:0] OFS_START   = 8'h1C;
  localparam logic [7:0] OFS_EVENT   = 8'h20;
  localparam logic [7:0] OFS_MASK    = 8'h24;
  localparam logic [7:0] OFS_FORCE   = 8'h28;

  localparam logic [KEY_W-1:0] KEY_RELOAD  = 16'hFEED;
  localparam logic [KEY_W-1:0] KEY_HALT_A  = 16'h2BAD;
  localparam logic [KEY_W-1:0] KEY_HALT_B  = 16'hCAFE;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hACED;
  localparam logic [KEY_W-1:0] KEY_CLEAR   = 16'hE8B4;
  localparam logic [KEY_W-1:0] CODE_HALTED = 16'hDABE;
  localparam logic [KEY_W-1:0] CODE_EXPIRE = 16'hCFE8;

  // Early-warning point: half of the programmed limit, rounded down.
  function automatic logic [CNT_W-1:0] warn_point(input logic [CNT_W-1:0] limit);
    return limit >> 1;
  endfunction

  // A key matches when the low half of the written word equals it.
  function automatic logic key_hit(input logic [31:0] wdata, input logic [KEY_W-1:0] key);
    return wdata[KEY_W-1:0] == key;
  endfunction
endpackage

// File: rtl/wdg_prescale.sv
`timescale 1ns/1ps
module wdg_prescale #(
  parameter int DIV = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] phase_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 phase_q <= '0;
        else if (clear_i)            phase_q <= '0;
        else if (run_i)              phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
      assign tick_o = run_i && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdg_downcount.sv
`timescale 1ns/1ps
module wdg_downcount
  import wdg_magic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             step_o,
  output logic             warn_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] next_val;

  assign step_o   = tick_i && !load_i && (count_q != '0);
  assign next_val = count_q - 1'b1;
  assign warn_o   = step_o && (next_val == warn_point(load_val_i));
  assign expire_o = step_o && (next_val == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '1;
    else if (load_i)  count_q <= load_val_i;
    else if (step_o)  count_q <= next_val;
  end

  assign count_o = count_q;
endmodule

// File: rtl/wdg_rstpulse.sv
`timescale 1ns/1ps
module wdg_rstpulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (start_i)         left_q <= LW'(LEN);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdg_regfile.sv
`timescale 1ns/1ps
module wdg_regfile
  import wdg_magic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              jtag_mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              step_i,
  input  logic              warn_i,
  input  logic              expire_i,
  output logic [CNT_W-1:0]  limit_o,
  output logic              load_o,
  output logic              run_o,
  output logic              enabled_o,
  output logic              expired_o,
  output logic              pend_o,
  output logic              mask_o
);
  logic [CNT_W-1:0] limit_q;
  logic enabled_q, armed_q, expired_q, pend_q, mask_q, dbg_en_q;
  logic [31:0] wd32;

  assign wd32 = 32'(wdata_i);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_reload, wr_start, wr_arm, wr_finish, wr_clear, wr_limit;
  logic wr_ack, wr_force, wr_mask, wr_debug;

  assign wr_reload = we_i && hit(addr_i, OFS_RELOAD) && key_hit(wd32, KEY_RELOAD);
  assign wr_start  = we_i && hit(addr_i, OFS_START)  && key_hit(wd32, KEY_START);
  assign wr_arm    = we_i && hit(addr_i, OFS_HALT_A) && key_hit(wd32, KEY_HALT_A);
  assign wr_finish = we_i && hit(addr_i, OFS_HALT_B) && key_hit(wd32, KEY_HALT_B) && armed_q;
  assign wr_clear  = we_i && hit(addr_i, OFS_EXPIRY) && key_hit(wd32, KEY_CLEAR);
  assign wr_limit  = we_i && hit(addr_i, OFS_LIMIT);
  assign wr_ack    = we_i && hit(addr_i, OFS_EVENT) && wd32[0];
  assign wr_force  = we_i && hit(addr_i, OFS_FORCE) && wd32[0];
  assign wr_mask   = we_i && hit(addr_i, OFS_MASK);
  assign wr_debug  = we_i && hit(addr_i, OFS_DEBUG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q   <= '1;
      enabled_q <= 1'b0;
      armed_q   <= 1'b0;
      expired_q <= 1'b0;
      pend_q    <= 1'b0;
      mask_q    <= 1'b0;
      dbg_en_q  <= 1'b0;
    end else begin
      if (wr_limit) limit_q <= wd32[CNT_W-1:0];
      if (we_i)     armed_q <= wr_arm;
      if (wr_start)       enabled_q <= 1'b1;
      else if (wr_finish) enabled_q <= 1'b0;
      if (expire_i)       expired_q <= 1'b1;
      else if (wr_clear)  expired_q <= 1'b0;
      if (warn_i || wr_force) pend_q <= 1'b1;
      else if (wr_ack)        pend_q <= 1'b0;
      if (wr_mask)  mask_q   <= wd32[0];
      if (wr_debug) dbg_en_q <= wd32[0];
    end
  end

  assign limit_o   = limit_q;
  assign load_o    = wr_reload || wr_start;
  assign run_o     = enabled_q && !(jtag_mode_i && !dbg_en_q);
  assign enabled_o = enabled_q;
  assign expired_o = expired_q;
  assign pend_o    = pend_q;
  assign mask_o    = mask_q;

  always_comb begin
    logic [31:0] r;
    r = '0;
    if (hit(addr_i, OFS_LIMIT))  r[CNT_W-1:0] = limit_q;
    if (hit(addr_i, OFS_HALT_B)) r[15:0] = enabled_q ? 16'h0000 : CODE_HALTED;
    if (hit(addr_i, OFS_EXPIRY)) r[15:0] = expired_q ? CODE_EXPIRE : 16'h0000;
    if (hit(addr_i, OFS_COUNT))  r[15:0] = {step_i, count_i};
    if (hit(addr_i, OFS_DEBUG))  r[1:0]  = {jtag_mode_i, dbg_en_q};
    if (hit(addr_i, OFS_EVENT))  r[0]    = pend_q;
    if (hit(addr_i, OFS_MASK))   r[0]    = mask_q;
    rdata_o = DATA_W'(r);
  end
endmodule

// File: rtl/wdg_magic_top.sv
`timescale 1ns/1ps
module wdg_magic_top
  import wdg_magic_pkg::*;
#(
  parameter int CLK_DIV = 2_000_000,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int RST_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              jtag_mode_i,
  output logic              irq_o,
  output logic              wdog_rst_o
);
  logic [CNT_W-1:0] limit_w, count_w;
  logic load_w, run_w, tick_w, step_w, warn_w, expire_w;
  logic enabled_w, expired_w, pend_w, mask_w;

  wdg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .jtag_mode_i(jtag_mode_i), .count_i(count_w), .step_i(step_w),
    .warn_i(warn_w), .expire_i(expire_w),
    .limit_o(limit_w), .load_o(load_w), .run_o(run_w), .enabled_o(enabled_w),
    .expired_o(expired_w), .pend_o(pend_w), .mask_o(mask_w)
  );

  wdg_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_w), .clear_i(load_w), .tick_o(tick_w)
  );

  wdg_downcount u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .load_i(load_w),
    .load_val_i(limit_w), .count_o(count_w), .step_o(step_w),
    .warn_o(warn_w), .expire_o(expire_w)
  );

  wdg_rstpulse #(.LEN(RST_LEN)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(expire_w), .pulse_o(wdog_rst_o)
  );

  assign irq_o = pend_w && mask_w;
endmodule

// File: rtl/wdg_magic_chk.sv
`timescale 1ns/1ps
module wdg_magic_chk #(
  parameter int CNT_W   = 15,
  parameter int RST_LEN = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_w,
  input logic             load_w,
  input logic             tick_w,
  input logic             run_w,
  input logic             enabled_w,
  input logic             jtag_mode_i,
  input logic             warn_w,
  input logic             expire_w,
  input logic             expired_w,
  input logic             pend_w,
  input logic             wdog_rst_o
);
  localparam int HW = $clog2(RST_LEN + 2);
  logic [HW-1:0] high_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         high_len <= '0;
    else if (wdog_rst_o) high_len <= high_len + 1'b1;
    else                 high_len <= '0;
  end

  // R3: one step per tick while running
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !load_w && count_w != '0) |=> (count_w == $past(count_w) - 1'b1));

  // R5: a stopped timer keeps its count
  a_r5_halted_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enabled_w && !load_w) |=> $stable(count_w));

  // R10: debug freeze keeps the count and produces no tick
  a_r10_debug_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w) |-> !tick_w);

  // R6: expiry latches the sticky code
  a_r6_expiry_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_w |=> expired_w);

  // R6: reset pulse never longer than its length
  a_r6_pulse_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdog_rst_o && high_len >= HW'(RST_LEN)));

  // R6: reset pulse ends only after its full length
  a_r6_pulse_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdog_rst_o) |-> (high_len == HW'(RST_LEN)));

  // R8: the early warning sets the pending bit
  a_r8_warn_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_w |=> pend_w);

  // R6: count holds at zero without a load
  a_r6_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_w == '0 && !load_w) |=> (count_w == '0));
endmodule

bind wdg_magic_top wdg_magic_chk #(.CNT_W(wdg_magic_pkg::CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .count_w(count_w), .load_w(load_w), .tick_w(tick_w),
  .run_w(run_w), .enabled_w(enabled_w), .jtag_mode_i(jtag_mode_i), .warn_w(warn_w),
  .expire_w(expire_w), .expired_w(expired_w), .pend_w(pend_w), .wdog_rst_o(wdog_rst_o)
);

// File: tb/wdg_magic_top_test.sv
`timescale 1ns/1ps
module wdg_magic_top_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        jtag = 1'b0;
  logic        irq, wrst;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdg_magic_top #(.CLK_DIV(DIV), .ADDR_W(8), .DATA_W(32), .RST_LEN(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .jtag_mode_i(jtag),
    .irq_o(irq), .wdog_rst_o(wrst)
  );

  // {write addr, write data, read addr, expected}
  localparam logic [47:0] VEC [10] = '{
    {8'h04, 16'h8005, 8'h04, 16'h0005},  // R2 bit 15 dropped
    {8'h1C, 16'h1234, 8'h0C, 16'hDABE},  // R3 wrong key ignored
    {8'h24, 16'h0001, 8'h24, 16'h0001},  // R8 mask set
    {8'h28, 16'h0000, 8'h20, 16'h0000},  // R9 zero does nothing
    {8'h28, 16'h0001, 8'h20, 16'h0001},  // R9 force
    {8'h20, 16'h0000, 8'h20, 16'h0001},  // R8 zero does not ack
    {8'h20, 16'h0001, 8'h20, 16'h0000},  // R8 ack
    {8'h10, 16'h1111, 8'h10, 16'h0000},  // R7 no expiry code
    {8'h18, 16'h0001, 8'h18, 16'h0001},  // R10 enable bit
    {8'h18, 16'h0000, 8'h18, 16'h0000}   // R10 enable bit clear
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    step(3);
    rst_n = 1'b1;
    #0.1;
    // R1 reset state
    rchk("R1", 8'h0C, 32'hDABE);
    rchk("R1", 8'h04, 32'h7FFF);
    rchk("R1", 8'h14, 32'h7FFF);
    rchk("R1", 8'h10, 32'h0000);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rst", {31'b0, wrst}, 32'd0);

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][47:40], {16'hFFFF, VEC[i][39:24]});
      rchk($sformatf("vector %0d R2/R3/R7/R8/R9/R10", i), VEC[i][23:16], {16'h0, VEC[i][15:0]});
    end

    wr(8'h04, 32'd8);
    rchk("R2", 8'h04, 32'd8);
    wr(8'h1C, 32'hACED);
    rchk("R5 running", 8'h0C, 32'h0000);
    rchk("R3 load", 8'h14, 32'd8);
    step(3);
    rchk("R11 tick cycle", 8'h14, 32'h8008);
    step(1);
    rchk("R3 R11 stepped", 8'h14, 32'd7);
    wr(8'h00, 32'hFEEE);
    rchk("R4 wrong key", 8'h14, 32'd7);
    wr(8'h00, 32'hFEED);
    rchk("R4 reload", 8'h14, 32'd8);
    step(15);
    rchk("R8 before warn", 8'h20, 32'd0);
    chk("R8 irq low", {31'b0, irq}, 32'd0);
    step(1);
    rchk("R3 count", 8'h14, 32'd4);
    rchk("R8 warn pending", 8'h20, 32'd1);
    chk("R8 irq high", {31'b0, irq}, 32'd1);
    wr(8'h20, 32'd1);
    rchk("R8 ack", 8'h20, 32'd0);
    step(14);
    rchk("R6 not yet", 8'h10, 32'h0000);
    chk("R6 rst low", {31'b0, wrst}, 32'd0);
    step(1);
    rchk("R6 expiry code", 8'h10, 32'hCFE8);
    chk("R6 rst rise", {31'b0, wrst}, 32'd1);
    rchk("R6 zero", 8'h14, 32'd0);
    step(15);
    chk("R6 rst last", {31'b0, wrst}, 32'd1);
    step(1);
    chk("R6 rst end", {31'b0, wrst}, 32'd0);
    step(8);
    rchk("R6 zero hold", 8'h14, 32'd0);

    wr(8'h10, 32'h1234);
    rchk("R7 wrong key", 8'h10, 32'hCFE8);
    wr(8'h10, 32'hE8B4);
    rchk("R7 clear", 8'h10, 32'h0000);

    wr(8'h24, 32'd0);
    wr(8'h28, 32'd1);
    chk("R8 masked", {31'b0, irq}, 32'd0);
    rchk("R9 forced", 8'h20, 32'd1);
    wr(8'h24, 32'd1);
    chk("R8 unmasked", {31'b0, irq}, 32'd1);
    wr(8'h20, 32'd1);
    rchk("R8 ack2", 8'h20, 32'd0);

    wr(8'h1C, 32'hACED);
    wr(8'h08, 32'h2BAD);
    wr(8'h0C, 32'hCAFF);
    wr(8'h0C, 32'hCAFE);
    rchk("R5 wrong second key", 8'h0C, 32'h0000);
    wr(8'h08, 32'h2BAD);
    wr(8'h00, 32'h0);
    wr(8'h0C, 32'hCAFE);
    rchk("R5 interrupted", 8'h0C, 32'h0000);
    wr(8'h08, 32'h2BAD);
    wr(8'h0C, 32'hCAFE);
    rchk("R5 halted", 8'h0C, 32'hDABE);
    rd(8'h14, held);
    step(20);
    rchk("R5 count held", 8'h14, {16'h0, held[15:0]});

    jtag = 1'b1;
    rchk("R10 mode bit", 8'h18, 32'd2);
    wr(8'h1C, 32'hACED);
    step(20);
    rchk("R10 frozen", 8'h14, 32'd8);
    wr(8'h18, 32'd1);
    rchk("R10 enable readback", 8'h18, 32'd3);
    step(4);
    rchk("R10 released", 8'h14, 32'd7);
    jtag = 1'b0;

    finish_run();
  end
endmodule